// File: doc/BRIEF.md
# Timer Compare/PWM Channel with Event Flag

This block is a single channel of a timer. It does not own a counter. It watches a shared counter value, a counting-direction bit and a wrap pulse, and compares them against its own 16-bit channel value. A two-bit mode field selects one of four behaviours:

- **Capture:** a chosen edge of an input pin loads the counter into the channel value.
- **Compare:** the output pin toggles on a match.
- **Edge-aligned PWM:** the output is asserted from the wrap until the match.
- **Centre-aligned PWM:** the output is asserted while the counter is below the channel value.

Every defined event sets a sticky event flag. Software clears the flag with a two-step handshake.

Software reaches the channel through a byte-wide port with three addresses: control/status, value high byte and value low byte. Reading the high byte freezes a copy of the low byte, so the two reads of a 16-bit value stay coherent. A debug-freeze input bypasses that buffer, so a debugger always sees the live value. A control write made during freeze discards a pending buffered byte.

Top module: `tmr_ch`

## Requirements
- R1: Bus address 0 is control/status: bits [1:0] mode (0 capture, 1 compare, 2 edge PWM, 3 centre PWM), bit 2 capture on falling edge when 1 (rising when 0), bit 7 event flag, bits 6..3 read 0. Address 1 is the value high byte and address 2 the low byte. Reset gives mode 0, value 0, flag 0, output 0. Read data is combinational in the cycle of the read strobe.
- R2: In edge PWM mode a counter equal to the value while counting up clears the output and sets the flag, both visible one cycle later. A wrap pulse sets the output unless the match happens in the same cycle. A match while counting down does neither.
- R3: In centre PWM mode the flag is set on a match in either counting direction. The output is registered as (counter < value).
- R4: In compare mode a match sets the flag and toggles the output one cycle later.
- R5: In capture mode the selected edge of the capture pin (compared with its value in the previous cycle) loads the counter into the value and sets the flag in the next cycle. The other edge has no effect, and the output stays 0.
- R6: In capture mode, bus writes to either value byte leave the value unchanged.
- R7: The flag clears only on a control write with bit 7 = 0 that follows a status read made while the flag was set. A write without that read, or with bit 7 = 1, leaves the flag set. The armed state persists until the flag clears.
- R8: When a flag-setting event and a clearing write fall in the same cycle, the flag stays set.
- R9: Outside freeze, a high-byte read captures the low byte. The next low-byte read returns the captured byte and releases it, even if the value changed in between.
- R10: During freeze, reads of either byte return the live value and neither capture nor release the buffer. A pending capture survives the freeze.
- R11: A control write during freeze discards a pending captured low byte. A control write outside freeze does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Shared counter value |
| cnt_down | input | 1 | Counter is counting down |
| cnt_wrap | input | 1 | One-cycle pulse when the counter wraps to its start |
| cap_pin | input | 1 | Capture input pin |
| dbg_freeze | input | 1 | Debug freeze active |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| ch_out | output | 1 | Channel output pin |
| ch_flag | output | 1 | Channel event flag |

## Verification
Each internal state of the channel shows at the ports within a known delay:

- **Match logic:** a faulty match or mode decode shows on `ch_out` or `ch_flag` one cycle after the counter value that should have triggered it.
- **Clear handshake:** a wrong arm bit shows only at the clearing write, as a flag that stays set or drops without a preceding status read.
- **Coherency buffer:** an error stays hidden until the next low-byte read, which may come many cycles later and after a freeze interval. The bench therefore changes the value between the high and low reads and toggles freeze inside that window.

// File: rtl/tmr_ch_pkg.sv
package tmr_ch_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_CAP  = 2'd0,
        MODE_CMP  = 2'd1,
        MODE_EPWM = 2'd2,
        MODE_CPWM = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_VHI  = 2'd1,
        ADR_VLO  = 2'd2,
        ADR_RSV  = 2'd3
    } addr_e;

    localparam int FLAG_POS = 7;
    localparam int EDGE_POS = 2;

    typedef struct packed {
        logic st_rd;
        logic st_wr;
        logic hi_rd;
        logic lo_rd;
        logic hi_wr;
        logic lo_wr;
    } bus_dec_t;

    function automatic logic [BYTE_W-1:0] pack_status(logic flag, logic cap_fall, mode_e m);
        logic [BYTE_W-1:0] r;
        r = '0;
        r[FLAG_POS] = flag;
        r[EDGE_POS] = cap_fall;
        r[1:0] = m;
        return r;
    endfunction

endpackage

// File: rtl/tmr_ch_flag.sv
module tmr_ch_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic st_rd,
    input  logic st_wr,
    input  logic wr_flag_bit,
    output logic flag
);
    logic flag_q, arm_q;
    logic flag_nxt, arm_nxt;

    always_comb begin
        flag_nxt = flag_q;
        if (set_evt)
            flag_nxt = 1'b1;
        else if (st_wr && !wr_flag_bit && arm_q)
            flag_nxt = 1'b0;

        arm_nxt = arm_q;
        if (!flag_nxt)
            arm_nxt = 1'b0;
        else if (st_rd && flag_q)
            arm_nxt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            flag_q <= flag_nxt;
            arm_q  <= arm_nxt;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/tmr_ch_valreg.sv
module tmr_ch_valreg #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_hi,
    input  logic                wr_lo,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                wr_block,
    input  logic                cap_load,
    input  logic [2*BYTE_W-1:0] cap_val,
    input  logic                freeze,
    input  logic                rd_hi,
    input  logic                rd_lo,
    input  logic                clr_hold,
    output logic [2*BYTE_W-1:0] val,
    output logic [BYTE_W-1:0]   hi_data,
    output logic [BYTE_W-1:0]   lo_data
);
    localparam int VAL_W = 2 * BYTE_W;
    localparam int LANES = VAL_W / BYTE_W;

    logic [VAL_W-1:0]  val_q;
    logic [BYTE_W-1:0] hold_q;
    logic              held_q;
    logic [LANES-1:0]  lane_wr;

    assign lane_wr = {wr_hi, wr_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else if (cap_load) begin
            val_q <= cap_val;
        end else if (!wr_block) begin
            for (int b = 0; b < LANES; b++) begin
                if (lane_wr[b])
                    val_q[b*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            hold_q <= '0;
        end else if (freeze) begin
            if (clr_hold)
                held_q <= 1'b0;
        end else if (rd_hi) begin
            held_q <= 1'b1;
            hold_q <= val_q[BYTE_W-1:0];
        end else if (rd_lo) begin
            held_q <= 1'b0;
        end
    end

    assign val     = val_q;
    assign hi_data = val_q[VAL_W-1:BYTE_W];
    assign lo_data = (held_q && !freeze) ? hold_q : val_q[BYTE_W-1:0];
endmodule

// File: rtl/tmr_ch_match.sv
module tmr_ch_match
    import tmr_ch_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode,
    input  logic             cap_fall,
    input  logic [VAL_W-1:0] cnt,
    input  logic             cnt_down,
    input  logic             cnt_wrap,
    input  logic [VAL_W-1:0] val,
    input  logic             cap_pin,
    output logic             set_evt,
    output logic             cap_load,
    output logic             ch_out
);
    logic cap_q, out_q, out_nxt;
    logic hit, below, cap_edge;

    assign hit      = (cnt == val);
    assign below    = (cnt < val);
    assign cap_edge = cap_fall ? (cap_q & ~cap_pin) : (~cap_q & cap_pin);

    always_comb begin
        set_evt  = 1'b0;
        cap_load = 1'b0;
        out_nxt  = out_q;
        case (mode)
            MODE_CAP: begin
                set_evt  = cap_edge;
                cap_load = cap_edge;
                out_nxt  = 1'b0;
            end
            MODE_CMP: begin
                set_evt = hit;
                if (hit)
                    out_nxt = ~out_q;
            end
            MODE_EPWM: begin
                set_evt = hit & ~cnt_down;
                if (hit && !cnt_down)
                    out_nxt = 1'b0;
                else if (cnt_wrap)
                    out_nxt = 1'b1;
            end
            default: begin
                set_evt = hit;
                out_nxt = below;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= 1'b0;
            out_q <= 1'b0;
        end else begin
            cap_q <= cap_pin;
            out_q <= out_nxt;
        end
    end

    assign ch_out = out_q;
endmodule

// File: rtl/tmr_ch.sv
module tmr_ch
    import tmr_ch_pkg::*;
#(
    parameter int BYTE_W = tmr_ch_pkg::BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2*BYTE_W-1:0] cnt_val,
    input  logic                cnt_down,
    input  logic                cnt_wrap,
    input  logic                cap_pin,
    input  logic                dbg_freeze,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    output logic                ch_out,
    output logic                ch_flag
);
    localparam int VAL_W = 2 * BYTE_W;

    bus_dec_t          dec;
    mode_e             mode_q;
    logic              cap_fall_q;
    logic [VAL_W-1:0]  val_w;
    logic [BYTE_W-1:0] hi_w, lo_w;
    logic              set_evt_w, cap_load_w;

    always_comb begin
        dec.st_rd = bus_rd && (bus_addr == ADR_CTRL);
        dec.st_wr = bus_wr && (bus_addr == ADR_CTRL);
        dec.hi_rd = bus_rd && (bus_addr == ADR_VHI);
        dec.lo_rd = bus_rd && (bus_addr == ADR_VLO);
        dec.hi_wr = bus_wr && (bus_addr == ADR_VHI);
        dec.lo_wr = bus_wr && (bus_addr == ADR_VLO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= MODE_CAP;
            cap_fall_q <= 1'b0;
        end else if (dec.st_wr) begin
            mode_q     <= mode_e'(bus_wdata[1:0]);
            cap_fall_q <= bus_wdata[EDGE_POS];
        end
    end

    tmr_ch_match #(.VAL_W(VAL_W)) u_match (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_q),
        .cap_fall (cap_fall_q),
        .cnt      (cnt_val),
        .cnt_down (cnt_down),
        .cnt_wrap (cnt_wrap),
        .val      (val_w),
        .cap_pin  (cap_pin),
        .set_evt  (set_evt_w),
        .cap_load (cap_load_w),
        .ch_out   (ch_out)
    );

    tmr_ch_valreg #(.BYTE_W(BYTE_W)) u_val (
        .clk      (clk),
        .rst      (rst),
        .wr_hi    (dec.hi_wr),
        .wr_lo    (dec.lo_wr),
        .wdata    (bus_wdata),
        .wr_block (mode_q == MODE_CAP),
        .cap_load (cap_load_w),
        .cap_val  (cnt_val),
        .freeze   (dbg_freeze),
        .rd_hi    (dec.hi_rd),
        .rd_lo    (dec.lo_rd),
        .clr_hold (dec.st_wr),
        .val      (val_w),
        .hi_data  (hi_w),
        .lo_data  (lo_w)
    );

    tmr_ch_flag u_flag (
        .clk         (clk),
        .rst         (rst),
        .set_evt     (set_evt_w),
        .st_rd       (dec.st_rd),
        .st_wr       (dec.st_wr),
        .wr_flag_bit (bus_wdata[FLAG_POS]),
        .flag        (ch_flag)
    );

    always_comb begin
        case (bus_addr)
            ADR_CTRL: bus_rdata = pack_status(ch_flag, cap_fall_q, mode_q);
            ADR_VHI:  bus_rdata = hi_w;
            ADR_VLO:  bus_rdata = lo_w;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_ch_chk.sv
module tmr_ch_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          mode,
    input logic [2*BYTE_W-1:0] cnt_val,
    input logic                cnt_down,
    input logic [2*BYTE_W-1:0] val,
    input logic                set_evt,
    input logic                cap_load,
    input logic                ch_out,
    input logic                ch_flag,
    input logic                dbg_freeze,
    input logic [1:0]          bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [BYTE_W-1:0]   bus_wdata,
    input logic [BYTE_W-1:0]   bus_rdata
);
    // R2
    epwm_match_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && !cnt_down && cnt_val == val) |=> (ch_flag && !ch_out));

    // R3
    cpwm_level_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3) |=> (ch_out == $past(cnt_val < val)));

    // R5
    cap_copy_chk: assert property (@(posedge clk) disable iff (rst)
        cap_load |=> ((val == $past(cnt_val)) && ch_flag));

    // R6
    cap_wr_block_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && bus_wr && bus_addr != 2'd0 && !cap_load) |=> $stable(val));

    // R7
    flag_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ch_flag) |-> $past(bus_wr && bus_addr == 2'd0 && !bus_wdata[BYTE_W-1]));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> ch_flag);

    // R10
    frz_live_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_freeze && bus_rd && bus_addr == 2'd2) |-> (bus_rdata == val[BYTE_W-1:0]));
endmodule

bind tmr_ch tmr_ch_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode_q),
    .cnt_val    (cnt_val),
    .cnt_down   (cnt_down),
    .val        (val_w),
    .set_evt    (set_evt_w),
    .cap_load   (cap_load_w),
    .ch_out     (ch_out),
    .ch_flag    (ch_flag),
    .dbg_freeze (dbg_freeze),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata)
);

// File: tb/tmr_ch_tb_top.sv
module tmr_ch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int NV         = 16;

    // {clr, mode[1:0], cnt[15:0], down, wrap, exp_out, exp_flag}
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 2'd2, 16'd0, 1'b0, 1'b1, 1'b1, 1'b0},
        {1'b0, 2'd2, 16'd5, 1'b1, 1'b0, 1'b1, 1'b0},
        {1'b0, 2'd2, 16'd3, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 2'd2, 16'd5, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b0, 2'd2, 16'd6, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b0, 2'd2, 16'd0, 1'b0, 1'b1, 1'b1, 1'b1},
        {1'b1, 2'd3, 16'd2, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 2'd3, 16'd5, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b0, 2'd3, 16'd7, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b1, 2'd3, 16'd7, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b0, 2'd3, 16'd5, 1'b1, 1'b0, 1'b0, 1'b1},
        {1'b0, 2'd3, 16'd4, 1'b1, 1'b0, 1'b1, 1'b1},
        {1'b1, 2'd1, 16'd4, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b0, 2'd1, 16'd5, 1'b0, 1'b0, 1'b1, 1'b1},
        {1'b0, 2'd1, 16'd6, 1'b0, 1'b0, 1'b1, 1'b1},
        {1'b1, 2'd1, 16'd5, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt_val = 16'hFFFF;
    logic        cnt_down = 1'b0;
    logic        cnt_wrap = 1'b0;
    logic        cap_pin = 1'b0;
    logic        dbg_freeze = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        ch_out, ch_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_ch dut_i (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_down(cnt_down),
        .cnt_wrap(cnt_wrap), .cap_pin(cap_pin), .dbg_freeze(dbg_freeze),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_out(ch_out), .ch_flag(ch_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        if (m == 2'd2) return "R2 edge pwm";
        if (m == 2'd3) return "R3 centre pwm";
        return "R4 compare";
    endfunction

    initial begin
        logic [7:0] d;
        logic [22:0] v;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk("R1 reset out", ch_out, 0);
        chk("R1 reset flag", ch_flag, 0);
        rd(2'd0, d); chk("R1 reset ctrl", d, 8'h00);
        dbg_freeze = 1'b1;
        rd(2'd1, d); chk("R1 reset value hi", d, 8'h00);
        rd(2'd2, d); chk("R1 reset value lo", d, 8'h00);
        dbg_freeze = 1'b0;

        // setup: compare mode, value 5
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h05);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            if (v[22]) begin
                cnt_val = 16'hFFFF; cnt_down = 1'b0; cnt_wrap = 1'b0;
                rd(2'd0, d);
                wr(2'd0, {6'd0, v[21:20]});
            end
            cnt_val  = v[19:4];
            cnt_down = v[3];
            cnt_wrap = v[2];
            tick();
            chk({mode_tag(v[21:20]), " out"}, ch_out, v[1]);
            chk({mode_tag(v[21:20]), " flag"}, ch_flag, v[0]);
        end
        cnt_val = 16'hFFFF; cnt_down = 1'b0; cnt_wrap = 1'b0;

        // R8: set and clear in the same cycle (compare mode, value 5, flag set)
        rd(2'd0, d);
        cnt_val = 16'd5;
        wr(2'd0, 8'h01);
        cnt_val = 16'hFFFF;
        chk("R8 flag kept on collision", ch_flag, 1);
        tick();
        chk("R8 flag still set", ch_flag, 1);
        rd(2'd0, d);
        wr(2'd0, 8'h01);
        chk("R7 clear after read", ch_flag, 0);

        // R7 handshake corners
        cnt_val = 16'd5; tick(); cnt_val = 16'hFFFF;
        wr(2'd0, 8'h01);
        chk("R7 write without read", ch_flag, 1);
        rd(2'd0, d); chk("R1 status flag bit", d, 8'h81);
        wr(2'd0, 8'h81);
        chk("R7 write of one", ch_flag, 1);
        wr(2'd0, 8'h01);
        chk("R7 armed clear", ch_flag, 0);

        // R1 control readback
        wr(2'd0, 8'h07);
        rd(2'd0, d); chk("R1 ctrl readback", d, 8'h07);
        wr(2'd0, 8'h01);

        // R9 coherent read
        wr(2'd1, 8'h12); wr(2'd2, 8'h34);
        rd(2'd1, d); chk("R9 hi read", d, 8'h12);
        wr(2'd2, 8'h99);
        rd(2'd2, d); chk("R9 buffered lo", d, 8'h34);
        rd(2'd2, d); chk("R9 released lo", d, 8'h99);

        // R10 freeze bypass
        rd(2'd1, d);
        wr(2'd2, 8'h55);
        dbg_freeze = 1'b1;
        rd(2'd2, d); chk("R10 live lo in freeze", d, 8'h55);
        rd(2'd1, d); chk("R10 live hi in freeze", d, 8'h12);
        dbg_freeze = 1'b0;
        rd(2'd2, d); chk("R10 buffer survives freeze", d, 8'h99);

        // R11 control write clears buffer only under freeze
        rd(2'd1, d);
        wr(2'd2, 8'h66);
        wr(2'd0, 8'h01);
        rd(2'd2, d); chk("R11 ctrl write outside freeze", d, 8'h55);
        rd(2'd1, d);
        wr(2'd2, 8'h77);
        dbg_freeze = 1'b1;
        wr(2'd0, 8'h01);
        dbg_freeze = 1'b0;
        rd(2'd2, d); chk("R11 ctrl write in freeze", d, 8'h77);

        // R6 capture mode blocks value writes
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hAB); wr(2'd2, 8'hCD);
        dbg_freeze = 1'b1;
        rd(2'd1, d); chk("R6 hi unchanged", d, 8'h12);
        rd(2'd2, d); chk("R6 lo unchanged", d, 8'h77);
        dbg_freeze = 1'b0;
        chk("R6 no flag", ch_flag, 0);
        chk("R5 capture out low", ch_out, 0);

        // R5 capture on rising edge
        cnt_val = 16'h0777; cap_pin = 1'b1; tick(); cnt_val = 16'hFFFF;
        chk("R5 rising capture flag", ch_flag, 1);
        dbg_freeze = 1'b1;
        rd(2'd1, d); chk("R5 captured hi", d, 8'h07);
        rd(2'd2, d); chk("R5 captured lo", d, 8'h77);
        dbg_freeze = 1'b0;
        cnt_val = 16'h0888; cap_pin = 1'b0; tick(); cnt_val = 16'hFFFF;
        dbg_freeze = 1'b1;
        rd(2'd2, d); chk("R5 falling ignored", d, 8'h77);
        dbg_freeze = 1'b0;

        // R5 capture on falling edge
        rd(2'd0, d);
        wr(2'd0, 8'h04);
        chk("R7 cleared in capture", ch_flag, 0);
        cnt_val = 16'h0999; cap_pin = 1'b1; tick(); cnt_val = 16'hFFFF;
        chk("R5 rising ignored flag", ch_flag, 0);
        cnt_val = 16'h0AAA; cap_pin = 1'b0; tick(); cnt_val = 16'hFFFF;
        chk("R5 falling capture flag", ch_flag, 1);
        dbg_freeze = 1'b1;
        rd(2'd1, d); chk("R5 falling hi", d, 8'h0A);
        rd(2'd2, d); chk("R5 falling lo", d, 8'hAA);
        dbg_freeze = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule